// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a clocked register bank for the command and address lines of a memory module. Two static straps select its shape. In the wide shape it registers 25 input bits one-to-one onto 25 outputs. In the duplicated shape it registers 14 input bits and drives each of them onto two outputs, so that one registered bit can feed two groups of loads. A second strap picks one of two output layouts for the duplicated shape: a lower-half layout and an upper-half layout.

Two active-low chip selects decide whether a clock edge loads new data. When both are high the bank keeps its contents, so the outputs do not toggle and switching power is saved. An active-low reset clears the bank at once and forces every output low, with or without a clock. Release is synchronous: the first clock edge after `rst_ni` rises only arms the bank, and capture starts on the edge after it. The straps are meant to be tied off. They are changed only while reset is held.

Top module: `regbuf`

## Requirements
- R1: With `dup_mode_i`=0, `q_o[i]` equals `data_i[i]` as sampled at the last loading rising edge, for every i from 0 to 24.
- R2: With `dup_mode_i`=0, the spare outputs `q_o[27:25]` are held at 0.
- R3: With `dup_mode_i`=1 and `half_sel_i`=0, for each i from 0 to 13 both `q_o[i]` and `q_o[i+14]` equal the registered `data_i[i]`.
- R4: With `dup_mode_i`=1 and `half_sel_i`=1, for each i from 0 to 13 both `q_o[2*i]` and `q_o[2*i+1]` equal the registered `data_i[11+i]`.
- R5: Data is taken only on the rising edge of `clk_i`. Input changes between edges do not reach `q_o`.
- R6: When both bits of `cs_n_i` are 1 at a rising edge, the bank keeps its value and `q_o` does not change, whatever `data_i` does.
- R7: When at least one bit of `cs_n_i` is 0 at a rising edge, new data is loaded.
- R8: While `rst_ni` is 0, every bit of `q_o` is 0. Reset takes effect without a clock edge, and edges during reset load nothing.
- R9: After `rst_ni` rises, the first rising edge loads nothing. The second rising edge is the first one that loads.
- R10: In the duplicated shape, input bits outside the selected half have no effect on `q_o`. In the lower-half layout these are bits 24..14. In the upper-half layout they are bits 10..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock. The rising edge stands for the differential crossing. |
| rst_ni | input | 1 | Asynchronous active-low reset with synchronous release. |
| dup_mode_i | input | 1 | Strap: 0 selects the wide one-to-one shape, 1 selects the duplicated shape. |
| half_sel_i | input | 1 | Strap: selects the layout in the duplicated shape (0 lower half, 1 upper half). |
| cs_n_i | input | 2 | Active-low chip selects. Both high holds the bank. |
| data_i | input | 25 | Command and address inputs. |
| q_o | output | 28 | Registered and mapped outputs. |

## Verification
A loading edge makes its data visible on `q_o` right after that edge, with one register and combinational mapping in between. The bench therefore drives inputs on the falling edge and samples at the next falling edge. A hold edge is checked in the same way, one edge later, with `q_o` unchanged. Reset is checked 1 ns after `rst_ni` falls, before any edge, to show that it does not wait for the clock. Release is checked across two edges, with no load on the first and a load on the second.

// File: rtl/regbuf_pkg.sv
`timescale 1ns/1ps
package regbuf_pkg;
  localparam int unsigned WIDE_BITS = 25;
  localparam int unsigned DUP_BITS  = 14;
  localparam int unsigned CS_BITS   = 2;

  typedef enum logic [1:0] {
    MAP_WIDE  = 2'd0,
    MAP_DUP_A = 2'd1,
    MAP_DUP_B = 2'd2
  } map_mode_e;

  function automatic map_mode_e decode_mode(logic dup, logic half);
    if (!dup)     return MAP_WIDE;
    else if (half) return MAP_DUP_B;
    else          return MAP_DUP_A;
  endfunction
endpackage

// File: rtl/regbuf_rst_ctl.sv
`timescale 1ns/1ps
// async assert, release arms the bank one edge later
module regbuf_rst_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end
  assign run_o = run_q;
endmodule

// File: rtl/regbuf_bank.sv
`timescale 1ns/1ps
module regbuf_bank #(
  parameter int unsigned WIDTH   = 25,
  parameter int unsigned CS_BITS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [CS_BITS-1:0] cs_n_i,
  input  logic [WIDTH-1:0]   d_i,
  output logic [WIDTH-1:0]   q_o
);
  logic             load;
  logic [WIDTH-1:0] q_q;

  // all selects high = hold
  assign load = run_i & ~(&cs_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (load) q_q <= d_i;
  end
  assign q_o = q_q;
endmodule

// File: rtl/regbuf_map.sv
`timescale 1ns/1ps
module regbuf_map
  import regbuf_pkg::*;
#(
  parameter int unsigned WIDE_BITS = 25,
  parameter int unsigned DUP_BITS  = 14,
  localparam int unsigned OUT_BITS = 2 * DUP_BITS,
  localparam int unsigned B_BASE   = WIDE_BITS - DUP_BITS
) (
  input  map_mode_e             mode_i,
  input  logic [WIDE_BITS-1:0]  r_i,
  output logic [OUT_BITS-1:0]   q_o
);
  for (genvar j = 0; j < OUT_BITS; j++) begin : g_out
    localparam int unsigned IDX_A = j % DUP_BITS;
    localparam int unsigned IDX_B = B_BASE + j / 2;
    logic wide_bit;
    if (j < WIDE_BITS) begin : g_used
      assign wide_bit = r_i[j];
    end else begin : g_spare
      assign wide_bit = 1'b0;
    end
    always_comb begin
      unique case (mode_i)
        MAP_DUP_A: q_o[j] = r_i[IDX_A];
        MAP_DUP_B: q_o[j] = r_i[IDX_B];
        default:   q_o[j] = wide_bit;
      endcase
    end
  end
endmodule

// File: rtl/regbuf.sv
`timescale 1ns/1ps
module regbuf
  import regbuf_pkg::*;
#(
  parameter int unsigned WIDE_BITS = regbuf_pkg::WIDE_BITS,
  parameter int unsigned DUP_BITS  = regbuf_pkg::DUP_BITS,
  parameter int unsigned CS_BITS   = regbuf_pkg::CS_BITS,
  localparam int unsigned OUT_BITS = 2 * DUP_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dup_mode_i,
  input  logic                 half_sel_i,
  input  logic [CS_BITS-1:0]   cs_n_i,
  input  logic [WIDE_BITS-1:0] data_i,
  output logic [OUT_BITS-1:0]  q_o
);
  logic                 run;
  logic [WIDE_BITS-1:0] bank_q;
  map_mode_e            mode;

  assign mode = decode_mode(dup_mode_i, half_sel_i);

  regbuf_rst_ctl i_rst_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  regbuf_bank #(
    .WIDTH   (WIDE_BITS),
    .CS_BITS (CS_BITS)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .cs_n_i (cs_n_i),
    .d_i    (data_i),
    .q_o    (bank_q)
  );

  regbuf_map #(
    .WIDE_BITS (WIDE_BITS),
    .DUP_BITS  (DUP_BITS)
  ) i_map (
    .mode_i (mode),
    .r_i    (bank_q),
    .q_o    (q_o)
  );
endmodule

// File: rtl/regbuf_chk.sv
`timescale 1ns/1ps
module regbuf_chk #(
  parameter int unsigned WIDE_BITS = 25,
  parameter int unsigned DUP_BITS  = 14,
  parameter int unsigned CS_BITS   = 2,
  localparam int unsigned OUT_BITS = 2 * DUP_BITS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dup_mode_i,
  input logic                 half_sel_i,
  input logic [CS_BITS-1:0]   cs_n_i,
  input logic [WIDE_BITS-1:0] data_i,
  input logic [OUT_BITS-1:0]  q_o
);
  logic [DUP_BITS-1:0] even_q, odd_q;
  for (genvar i = 0; i < DUP_BITS; i++) begin : g_pair
    assign even_q[i] = q_o[2*i];
    assign odd_q[i]  = q_o[2*i+1];
  end

  assert_spare_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_mode_i |-> q_o[OUT_BITS-1:WIDE_BITS] == '0);

  assert_pair_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_mode_i && !half_sel_i) |-> q_o[DUP_BITS-1:0] == q_o[OUT_BITS-1:DUP_BITS]);

  assert_pair_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_mode_i && half_sel_i) |-> even_q == odd_q);

  assert_cs_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&$past(cs_n_i)) && $stable(dup_mode_i) && $stable(half_sel_i)) |-> $stable(q_o));

  assert_wide_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2) && !(&$past(cs_n_i)) && !dup_mode_i && $stable(dup_mode_i))
      |-> q_o[WIDE_BITS-1:0] == $past(data_i));
endmodule

bind regbuf regbuf_chk #(
  .WIDE_BITS (WIDE_BITS),
  .DUP_BITS  (DUP_BITS),
  .CS_BITS   (CS_BITS)
) i_regbuf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dup_mode_i (dup_mode_i),
  .half_sel_i (half_sel_i),
  .cs_n_i     (cs_n_i),
  .data_i     (data_i),
  .q_o        (q_o)
);

// File: tb/test_regbuf.sv
`timescale 1ns/1ps
module test_regbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dup = 1'b0;
  logic        half = 1'b0;
  logic [1:0]  cs_n = 2'b00;
  logic [24:0] data = '0;
  logic [27:0] q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  regbuf i_regbuf (
    .clk_i(clk), .rst_ni(rst_n), .dup_mode_i(dup), .half_sel_i(half),
    .cs_n_i(cs_n), .data_i(data), .q_o(q)
  );

  function automatic logic [27:0] exp_map(logic [24:0] r, logic d, logic h);
    logic [27:0] e = '0;
    if (!d) e[24:0] = r;
    else if (!h) for (int i = 0; i < 14; i++) begin e[i] = r[i]; e[i+14] = r[i]; end
    else for (int i = 0; i < 14; i++) begin e[2*i] = r[11+i]; e[2*i+1] = r[11+i]; end
    return e;
  endfunction

  task automatic chk(string req, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [24:0] d, logic [1:0] cs);
    data = d; cs_n = cs;
    @(posedge clk); @(negedge clk);
  endtask

  // reset, set straps, release, spend the arming edge
  task automatic restart(logic d, logic h);
    @(negedge clk);
    rst_n = 1'b0; dup = d; half = h; cs_n = 2'b00;
    @(posedge clk); @(negedge clk);
    chk("R8 reset state", q, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_release;
    @(negedge clk);
    rst_n = 1'b0; dup = 1'b0; half = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; data = 25'h1ABCDEF; cs_n = 2'b00;
    @(posedge clk); @(negedge clk);
    chk("R9 first edge after release loads nothing", q, '0);
    @(posedge clk); @(negedge clk);
    chk("R9 second edge loads", q, exp_map(25'h1ABCDEF, 1'b0, 1'b0));
  endtask

  task automatic t_wide;
    logic [24:0] pats [4] = '{25'h1FFFFFF, 25'h0AAAAAA, 25'h1555555, 25'h0000001};
    restart(1'b0, 1'b0);
    foreach (pats[k]) begin
      step(pats[k], 2'b00);
      chk("R1 wide capture", q, exp_map(pats[k], 1'b0, 1'b0));
      chk("R2 spare outputs low", {25'b0, q[27:25]}, '0);
    end
    // change between edges
    data = 25'h0123456; #3;
    chk("R5 no change before edge", q, exp_map(25'h0000001, 1'b0, 1'b0));
    @(posedge clk); @(negedge clk);
    chk("R5 change after edge", q, exp_map(25'h0123456, 1'b0, 1'b0));
  endtask

  task automatic t_dup_a;
    restart(1'b1, 1'b0);
    step(25'h0002A5B, 2'b01);
    chk("R3 lower half duplicated", q, exp_map(25'h0002A5B, 1'b1, 1'b0));
    step(25'h1FFC000 | 25'h0002A5B, 2'b10);
    chk("R10 upper bits ignored in lower layout", q, exp_map(25'h0002A5B, 1'b1, 1'b0));
    step(25'h0001234, 2'b00);
    chk("R3 second pattern", q, exp_map(25'h0001234, 1'b1, 1'b0));
  endtask

  task automatic t_dup_b;
    restart(1'b1, 1'b1);
    step(25'h15A5800, 2'b00);
    chk("R4 upper half interleaved", q, exp_map(25'h15A5800, 1'b1, 1'b1));
    step(25'h15A5800 | 25'h00007FF, 2'b00);
    chk("R10 lower bits ignored in upper layout", q, exp_map(25'h15A5800, 1'b1, 1'b1));
    step(25'h0A5A000, 2'b01);
    chk("R4 second pattern", q, exp_map(25'h0A5A000, 1'b1, 1'b1));
  endtask

  task automatic t_cs;
    restart(1'b0, 1'b0);
    step(25'h0F0F0F0, 2'b00);
    step(25'h10F0F0F, 2'b11);
    chk("R6 both selects high hold", q, exp_map(25'h0F0F0F0, 1'b0, 1'b0));
    step(25'h0333333, 2'b11);
    chk("R6 hold second edge", q, exp_map(25'h0F0F0F0, 1'b0, 1'b0));
    step(25'h0333333, 2'b10);
    chk("R7 select bit0 low loads", q, exp_map(25'h0333333, 1'b0, 1'b0));
    step(25'h1444444, 2'b01);
    chk("R7 select bit1 low loads", q, exp_map(25'h1444444, 1'b0, 1'b0));
  endtask

  task automatic t_reset_mid;
    restart(1'b1, 1'b0);
    step(25'h0003FFF, 2'b00);
    step(25'h0001555, 2'b00);
    chk("R3 stream before reset", q, exp_map(25'h0001555, 1'b1, 1'b0));
    #5 rst_n = 1'b0;
    #1 chk("R8 async clear without edge", q, '0);
    data = 25'h0002AAA;
    @(posedge clk); @(negedge clk);
    chk("R8 edge in reset loads nothing", q, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 arming edge after mid-stream reset", q, '0);
    @(posedge clk); @(negedge clk);
    chk("R9 load resumes", q, exp_map(25'h0002AAA, 1'b1, 1'b0));
  endtask

  initial begin
    #1 chk("R8 reset at start", q, '0);
    t_release();
    t_wide();
    t_dup_a();
    t_dup_b();
    t_cs();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule